// File: doc/BRIEF.md
# Four-Lane Multiply-Accumulate FIR Engine

This block is the arithmetic core of a time-multiplexed FIR filter. It has four lanes. Each lane keeps a short stack of recent input samples and its own bank of coefficients. On every clock, each lane takes a tap index and reads the sample and the coefficient stored at that index. The four lanes multiply their pairs, the four products are added, and that sum either starts a new accumulation or is added to the running total. A filter pass therefore costs one clock for every four taps. The same four multipliers serve every tap.

A sequencer outside the block supplies the per-lane tap indices, the accumulate control and the push strobes. Between passes it pushes a fresh sample onto a lane's stack. The result is a saturating 24-bit accumulator. It is also available as a 16-bit upper slice, which can be rounded to nearest or simply truncated. Coefficients are loaded through a lane-addressed write port.

Top module: `quad_mac_fir`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `acc_out`, `rnd_out`, `out_vld` and every entry of all four sample stacks.
- R2: A low `push_n[l]` at an edge stores `smp_in[l]` at stack entry 0 of lane l, moves each entry k to k+1 and drops entry 15. A high `push_n[l]` leaves lane l's stack unchanged. Lane indices are 0 to 3.
- R3: With `cw_we` high at an edge, `cw_data` is written to coefficient `cw_addr` of lane `cw_lane` (0 to 3). Tap indices presented at later edges read the new value, and the banks of the other lanes are not changed.
- R4: Tap index k on `tap_sel[l]` selects stack entry k (0 is the newest) and coefficient k of lane l. Each lane uses its own index.
- R5: Samples and coefficients are 10-bit signed. With `acc_en` low, `acc_out` becomes the sum of the four lane products, sign-extended to 24 bits.
- R6: With `acc_en` high, the four-product sum is added to the accumulator value of the previous cycle.
- R7: The accumulator saturates at +8388607 and -8388608 and never wraps.
- R8: `acc_out` reflects the inputs sampled three rising edges earlier. `out_vld` equals `acc_en` delayed by the same three edges.
- R9: With `rnd_en` high (sampled with the tap indices), `rnd_out` is floor((acc+128)/256), limited to +32767. With `rnd_en` low, it is `acc_out[23:8]`.
- R10: A read and a push, or a read and a coefficient write, on the same edge return the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_in | input | 4x10 | Per-lane input sample, signed |
| push_n | input | 4 | Per-lane push strobe, active low |
| tap_sel | input | 4x4 | Per-lane tap index |
| acc_en | input | 1 | 1 adds to the running total, 0 loads a new sum |
| rnd_en | input | 1 | 1 rounds the 16-bit output |
| cw_we | input | 1 | Coefficient write strobe |
| cw_lane | input | 2 | Coefficient write lane |
| cw_addr | input | 4 | Coefficient write index |
| cw_data | input | 10 | Coefficient value, signed |
| acc_out | output | 24 | Saturated accumulator |
| rnd_out | output | 16 | Upper 16 bits, rounded or truncated |
| out_vld | output | 1 | Delayed accumulate control |

## Verification
Every accumulator, rounded-output and flag value is due after the third rising edge that follows the cycle in which its tap indices, controls and `rnd_en` were driven. Pushes and coefficient writes take effect on the first edge, so they can first be seen by indices driven in the next cycle. The bench drives each cycle's inputs at the falling edge and computes the expected result at once from its own model of the stacks and banks, using their contents from before that edge. It queues the result three deep and compares it with the outputs at the falling edge after the third rising edge. The reset state is sampled at the falling edge while reset is still applied.

// File: rtl/qmf_pkg.sv
package qmf_pkg;
  // control bits that travel with the tap reads down the pipeline
  typedef struct packed {
    logic acc;
    logic rnd;
  } qmf_ctl_t;
endpackage

// File: rtl/qmf_lane.sv
module qmf_lane #(
  parameter int DW    = 10,
  parameter int CW    = 10,
  parameter int DEPTH = 16,
  localparam int SELW = $clog2(DEPTH),
  localparam int PW   = DW + CW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   din,
  input  logic            push_n,
  input  logic [SELW-1:0] sel,
  input  logic            cw_we,
  input  logic [SELW-1:0] cw_addr,
  input  logic [CW-1:0]   cw_data,
  output logic [PW-1:0]   prod_o
);
  logic signed [DW-1:0] stk [DEPTH];
  logic signed [CW-1:0] cmem [DEPTH];
  logic signed [DW-1:0] d_q;
  logic signed [CW-1:0] c_q;
  logic signed [PW-1:0] p_q;

  // sample stack: entry 0 newest, a push shifts every entry one place
  always_ff @(posedge clk) begin
    if (rst) stk[0] <= '0;
    else if (!push_n) stk[0] <= din;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stk
    always_ff @(posedge clk) begin
      if (rst) stk[k] <= '0;
      else if (!push_n) stk[k] <= stk[k-1];
    end
  end

  // coefficient bank: one write port and a registered read, read-first
  always_ff @(posedge clk) begin
    if (cw_we) cmem[cw_addr] <= cw_data;
    c_q <= cmem[sel];
  end

  // stage 1 sample read, stage 2 product
  always_ff @(posedge clk) begin
    if (rst) begin
      d_q <= '0;
      p_q <= '0;
    end else begin
      d_q <= stk[sel];
      p_q <= PW'(d_q) * PW'(c_q);
    end
  end

  assign prod_o = p_q;
endmodule

// File: rtl/qmf_sum.sv
module qmf_sum #(
  parameter int LANES = 4,
  parameter int PW    = 20,
  localparam int SW   = PW + $clog2(LANES)
) (
  input  logic [LANES-1:0][PW-1:0] prod_i,
  output logic [SW-1:0]            sum_o
);
  logic signed [SW-1:0] acc_s;

  always_comb begin
    acc_s = '0;
    for (int l = 0; l < LANES; l++) acc_s = acc_s + SW'($signed(prod_i[l]));
  end

  assign sum_o = acc_s;
endmodule

// File: rtl/qmf_acc.sv
module qmf_acc #(
  parameter int SW = 22,
  parameter int AW = 24,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] sum_i,
  input  logic          acc_i,
  input  logic          rnd_i,
  output logic [AW-1:0] acc_o,
  output logic [OW-1:0] hi_o,
  output logic          vld_o
);
  localparam logic signed [AW-1:0] AMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] AMIN = {1'b1, {(AW-1){1'b0}}};
  localparam logic signed [OW-1:0] OMAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic signed [AW:0]   HALF = (AW+1)'(1) << (AW-OW-1);

  logic signed [AW-1:0] acc_q, ext, nxt;
  logic signed [AW:0]   wide, rw;
  logic signed [OW-1:0] hi_d, hi_q;
  logic                 vld_q;

  always_comb begin
    ext  = AW'($signed(sum_i));
    wide = acc_i ? ((AW+1)'(acc_q) + (AW+1)'(ext)) : (AW+1)'(ext);
    if (wide[AW] != wide[AW-1]) nxt = wide[AW] ? AMIN : AMAX;
    else                        nxt = wide[AW-1:0];
    rw = (AW+1)'(nxt) + HALF;
    if (!rnd_i)                   hi_d = nxt[AW-1 -: OW];
    else if (rw[AW] != rw[AW-1])  hi_d = OMAX;
    else                          hi_d = rw[AW-1 -: OW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      hi_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= nxt;
      hi_q  <= hi_d;
      vld_q <= acc_i;
    end
  end

  assign acc_o = acc_q;
  assign hi_o  = hi_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/quad_mac_fir.sv
module quad_mac_fir
  import qmf_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 10,
  parameter int CW    = 10,
  parameter int DEPTH = 16,
  parameter int AW    = 24,
  parameter int OW    = 16,
  localparam int SELW = $clog2(DEPTH),
  localparam int LSW  = $clog2(LANES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0][DW-1:0]  smp_in,
  input  logic [LANES-1:0]          push_n,
  input  logic [LANES-1:0][SELW-1:0] tap_sel,
  input  logic                      acc_en,
  input  logic                      rnd_en,
  input  logic                      cw_we,
  input  logic [LSW-1:0]            cw_lane,
  input  logic [SELW-1:0]           cw_addr,
  input  logic [CW-1:0]             cw_data,
  output logic [AW-1:0]             acc_out,
  output logic [OW-1:0]             rnd_out,
  output logic                      out_vld
);
  localparam int PW = DW + CW;
  localparam int SW = PW + $clog2(LANES);

  logic [LANES-1:0][PW-1:0] prod;
  logic [SW-1:0]            sum;
  qmf_ctl_t                 ctl1, ctl2;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    qmf_lane #(.DW(DW), .CW(CW), .DEPTH(DEPTH)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .din     (smp_in[l]),
      .push_n  (push_n[l]),
      .sel     (tap_sel[l]),
      .cw_we   (cw_we && (cw_lane == LSW'(l))),
      .cw_addr (cw_addr),
      .cw_data (cw_data),
      .prod_o  (prod[l])
    );
  end

  // controls follow the two lane stages
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl1 <= '0;
      ctl2 <= '0;
    end else begin
      ctl1 <= '{acc: acc_en, rnd: rnd_en};
      ctl2 <= ctl1;
    end
  end

  qmf_sum #(.LANES(LANES), .PW(PW)) u_sum (
    .prod_i (prod),
    .sum_o  (sum)
  );

  qmf_acc #(.SW(SW), .AW(AW), .OW(OW)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .sum_i (sum),
    .acc_i (ctl2.acc),
    .rnd_i (ctl2.rnd),
    .acc_o (acc_out),
    .hi_o  (rnd_out),
    .vld_o (out_vld)
  );
endmodule

// File: rtl/qmf_chk.sv
module qmf_chk #(
  parameter int LANES = 4,
  parameter int DW    = 10,
  parameter int CW    = 10,
  parameter int AW    = 24,
  parameter int OW    = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_en,
  input logic          rnd_en,
  input logic [AW-1:0] acc_out,
  input logic [OW-1:0] rnd_out,
  input logic          out_vld
);
  localparam logic signed [AW-1:0] LIM = AW'(LANES) << (DW + CW - 2);

  logic [2:0]           live;
  logic signed [AW-1:0] accs;
  assign accs = acc_out;

  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else if (live != 3'd7) live <= live + 3'd1;
  end

  p_valid_lag_r8: assert property (@(posedge clk) disable iff (rst)
    (live >= 3'd4) |-> (out_vld == $past(acc_en, 3)));

  p_trunc_r9: assert property (@(posedge clk) disable iff (rst)
    (live >= 3'd4 && !$past(rnd_en, 3)) |-> (rnd_out == acc_out[AW-1 -: OW]));

  p_round_step_r9: assert property (@(posedge clk) disable iff (rst)
    (live >= 3'd4 && $past(rnd_en, 3)) |-> (OW'(rnd_out - acc_out[AW-1 -: OW]) <= OW'(1)));

  p_load_bound_r5: assert property (@(posedge clk) disable iff (rst)
    (live >= 3'd4 && !$past(acc_en, 3)) |-> (accs <= LIM && accs >= -LIM));

  p_no_wrap_pos_r7: assert property (@(posedge clk) disable iff (rst)
    (live >= 3'd5 && $past(acc_en, 3) && $past(acc_out[AW-1 -: 2]) == 2'b01) |-> !acc_out[AW-1]);

  p_no_wrap_neg_r7: assert property (@(posedge clk) disable iff (rst)
    (live >= 3'd5 && $past(acc_en, 3) && $past(acc_out[AW-1 -: 2]) == 2'b10) |-> acc_out[AW-1]);
endmodule

bind quad_mac_fir qmf_chk #(.LANES(LANES), .DW(DW), .CW(CW), .AW(AW), .OW(OW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .acc_en  (acc_en),
  .rnd_en  (rnd_en),
  .acc_out (acc_out),
  .rnd_out (rnd_out),
  .out_vld (out_vld)
);

// File: tb/test_quad_mac_fir.sv
module test_quad_mac_fir;
  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [3:0][9:0] smp_in = '0;
  logic [3:0]      push_n = '1;
  logic [3:0][3:0] tap_sel = '0;
  logic            acc_en = 1'b0, rnd_en = 1'b0, cw_we = 1'b0;
  logic [1:0]      cw_lane = '0;
  logic [3:0]      cw_addr = '0;
  logic [9:0]      cw_data = '0;
  logic [23:0]     acc_out;
  logic [15:0]     rnd_out;
  logic            out_vld;

  int n_chk = 0, n_fail = 0, n_step = 0;
  bit done = 0;
  int stk_m [4][16];
  int cf_m  [4][16];
  int acc_m = 0;
  int    qa [3], qr [3], qv [3];
  string qt [3];

  always #5 clk = ~clk;

  quad_mac_fir i_quad_mac_fir (
    .clk(clk), .rst(rst), .smp_in(smp_in), .push_n(push_n), .tap_sel(tap_sel),
    .acc_en(acc_en), .rnd_en(rnd_en), .cw_we(cw_we), .cw_lane(cw_lane),
    .cw_addr(cw_addr), .cw_data(cw_data), .acc_out(acc_out), .rnd_out(rnd_out),
    .out_vld(out_vld)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, n_step);
    end
  endtask

  function automatic int sat24(input int v);
    if (v > 8388607) return 8388607;
    if (v < -8388608) return -8388608;
    return v;
  endfunction

  function automatic int round16(input int a, input bit en);
    int r;
    if (!en) return a >>> 8;
    r = (a + 128) >>> 8;
    return (r > 32767) ? 32767 : r;
  endfunction

  task automatic idle();
    push_n = '1; cw_we = 1'b0; acc_en = 1'b0;
  endtask

  // model the cycle being driven, queue it, pass one edge, compare the result due now
  task automatic step(input string tag);
    int s, raw;
    s = 0;
    for (int l = 0; l < 4; l++) s += stk_m[l][tap_sel[l]] * cf_m[l][tap_sel[l]];
    raw   = acc_en ? acc_m + s : s;
    acc_m = sat24(raw);
    for (int i = 2; i > 0; i--) begin
      qa[i] = qa[i-1]; qr[i] = qr[i-1]; qv[i] = qv[i-1]; qt[i] = qt[i-1];
    end
    qa[0] = acc_m;
    qr[0] = round16(acc_m, rnd_en);
    qv[0] = int'(acc_en);
    if (tag != "")          qt[0] = tag;
    else if (raw != acc_m)  qt[0] = "R7";
    else if (acc_en)        qt[0] = "R6";
    else                    qt[0] = "R5";
    if (cw_we) cf_m[cw_lane][cw_addr] = int'($signed(cw_data));
    for (int l = 0; l < 4; l++)
      if (!push_n[l]) begin
        for (int k = 15; k > 0; k--) stk_m[l][k] = stk_m[l][k-1];
        stk_m[l][0] = int'($signed(smp_in[l]));
      end
    n_step++;
    @(negedge clk);
    if (n_step >= 3) begin
      check(qt[2], int'($signed(acc_out)), qa[2]);
      check("R9", int'($signed(rnd_out)), qr[2]);
      check("R8", int'(out_vld), qv[2]);
    end
  endtask

  task automatic fill_coefs(input int mode);
    for (int l = 0; l < 4; l++)
      for (int a = 0; a < 16; a++) begin
        idle();
        cw_we = 1'b1; cw_lane = 2'(l); cw_addr = 4'(a);
        case (mode)
          0: cw_data = (l == 0) ? 10'd1 : 10'd0;
          1: cw_data = 10'($urandom);
          2: cw_data = 10'h200;
          default: cw_data = 10'h1FF;
        endcase
        step("");
      end
    idle();
  endtask

  task automatic fill_stacks(input logic [9:0] v, input bit rnd);
    for (int k = 0; k < 16; k++) begin
      idle();
      push_n = 4'b0000;
      for (int l = 0; l < 4; l++) smp_in[l] = rnd ? 10'($urandom) : v;
      step("");
    end
    idle();
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int l = 0; l < 4; l++)
      for (int k = 0; k < 16; k++) begin stk_m[l][k] = 0; cf_m[l][k] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(acc_out), 0);
    check("R1", int'(rnd_out), 0);
    check("R1", int'(out_vld), 0);
    rst = 1'b0;

    fill_coefs(0);
    // R1: stacks read back as zero after reset
    for (int k = 0; k < 4; k++) begin tap_sel = {4{4'(k)}}; step("R1"); end

    // R2: 17 pushes on lane 0, the first one drops out
    for (int k = 0; k < 17; k++) begin
      idle(); push_n = 4'b1110; smp_in[0] = 10'(k * 3 + 1); tap_sel = '0; step("R2");
    end
    idle();
    for (int k = 0; k < 16; k++) begin tap_sel = '0; tap_sel[0] = 4'(k); step("R2"); end

    // R10: a read and a push on the same edge see the old entry 0
    tap_sel = '0; push_n = 4'b1110; smp_in[0] = 10'h3F0; step("R10");
    idle(); step("R10");
    // R10: a read and a coefficient write on the same edge
    cw_we = 1'b1; cw_lane = 2'd0; cw_addr = 4'd0; cw_data = 10'd9; step("R10");
    idle(); step("R10");

    // R3: lane-addressed writes leave other lanes alone
    push_n = 4'b1011; smp_in[2] = 10'd7; step("R3");
    idle(); cw_we = 1'b1; cw_lane = 2'd2; cw_addr = 4'd0; cw_data = 10'h3FD; step("R3");
    idle(); cw_we = 1'b1; cw_lane = 2'd3; cw_addr = 4'd0; cw_data = 10'd5; step("R3");
    idle(); step("R3"); step("R3");

    // R4: independent per-lane indices
    fill_coefs(1);
    fill_stacks('0, 1'b1);
    for (int i = 0; i < 24; i++) begin
      for (int l = 0; l < 4; l++) tap_sel[l] = 4'($urandom);
      step("R4");
    end

    // R6: running sums
    for (int i = 0; i < 12; i++) begin
      acc_en = (i != 0);
      for (int l = 0; l < 4; l++) tap_sel[l] = 4'($urandom);
      step("");
    end
    idle();

    // R7: drive to both limits, rounding on at the top
    fill_coefs(2);
    fill_stacks(10'h200, 1'b0);
    rnd_en = 1'b1;
    for (int i = 0; i < 12; i++) begin acc_en = 1'b1; step(""); end
    fill_coefs(3);
    for (int i = 0; i < 22; i++) begin acc_en = 1'b1; step(""); end
    idle(); rnd_en = 1'b0; step("");

    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      for (int l = 0; l < 4; l++) begin
        smp_in[l] = 10'($urandom); tap_sel[l] = 4'($urandom);
      end
      push_n  = 4'($urandom);
      acc_en  = ($urandom % 5) != 0;
      rnd_en  = 1'($urandom);
      cw_we   = ($urandom % 4) == 0;
      cw_lane = 2'($urandom); cw_addr = 4'($urandom); cw_data = 10'($urandom);
      step("");
    end
    idle();
    repeat (3) step("");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule